// File: doc/BRIEF.md
# Peripheral Event Transfer Channel

This block is a small data mover that serves eight interrupt sources. Each source has its own channel holding a source address, a destination address, a service counter and two mode bits. A pulse on a channel's trigger input asks for one service. A service reads one item (a byte or a 16-bit word) from the source address, writes it to the destination address, advances exactly one of the two addresses, and counts the service. The CPU loses only the bus slot used for that single move.

The counter sets how many services a channel grants. Once the counter has reached zero, the next trigger on that channel performs no move. It raises a one-cycle interrupt request on that channel's output, so the normal interrupt handler can take over. The counter value 0xFF marks a channel as continuous: it moves data on every trigger and never counts down. Triggers that arrive together are served one at a time, lowest channel index first. Triggers that cannot be served yet stay pending.

Software sets up the channels through a simple write port. A memory master port with a request/acknowledge handshake carries the transfers.

Top module: `pet_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req`, `done_o` and every bit of `irq_o` are low.
- R2: A channel whose control word has bit 8 clear moves a byte. During both accesses `mem_word` is 0. The byte read from the source address (`mem_rdata[7:0]`) is written to the destination address with `mem_wdata[15:8]` zero.
- R3: A channel whose control word has bit 8 set moves a 16-bit word. During both accesses `mem_word` is 1, and the full `mem_rdata` value read is written unchanged.
- R4: Control word bit 9 selects which address advances after a completed service: 1 advances the source, 0 advances the destination. The step is 1 for byte moves and 2 for word moves. The other address is unchanged.
- R5: Each completed service lowers the counter (control bits 7:0) by one. A trigger on a channel whose counter is 0 performs no memory access. Two cycles after the trigger edge it gives a one-cycle pulse on that channel's `irq_o` bit, and the counter stays 0.
- R6: A counter value of 0xFF never decrements. Such a channel moves data on every trigger and never raises `irq_o`.
- R7: When several channels are pending, the lowest-numbered one is served first. The others remain pending and are served later without a new trigger.
- R8: A service is one read followed by one write. Each request is held with a stable address and direction until `mem_ack`. After the write is acknowledged, `done_o` pulses for one cycle with `done_ch` naming the channel.
- R9: A trigger on a channel that is being served is kept pending, and that channel is served once more afterwards.
- R10: Configuration writes use `cfg_sel`: 0 = control word, 1 = source address, 2 = destination address. A write takes effect on the next clock. It takes precedence over a pointer or counter update to the same channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 8 | Per-channel service request pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel addressed by the configuration write |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination |
| cfg_wdata | input | 16 | Configuration write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Access completion |
| done_o | output | 1 | One-cycle pulse when a service completes |
| done_ch | output | 3 | Channel of the completed service |
| irq_o | output | 8 | One-cycle interrupt request pulse per channel |

## Verification
A wrong address register or step shows on `mem_addr` at the next service of that channel: the read or the write lands one or two bytes away from the expected place. A corrupted counter shows later. The interrupt pulse comes one service too early or too late, or a continuous channel starts to raise it. This can take as many triggers as the count programmed. A fault in pending tracking or priority shows as a wrong `done_ch` order within a few services, or as a service that never arrives. The stimulus therefore chains repeated triggers on each channel and checks both addresses of every follow-up access.

// File: rtl/pet_pkg.sv
package pet_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } pet_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_SRC  = 2'd1;
    localparam logic [1:0] SEL_DST  = 2'd2;

endpackage

// File: rtl/pet_pick.sv
module pet_pick #(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end
endmodule

// File: rtl/pet_chan_bank.sv
module pet_chan_bank
    import pet_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int DW  = 16,
    localparam int CHW   = $clog2(NCH),
    localparam int WSTEP = DW / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CHW-1:0]          cfg_ch,
    input  logic [1:0]              cfg_sel,
    input  logic [AW-1:0]           cfg_wdata,
    input  logic                    upd,
    input  logic [CHW-1:0]          upd_ch,
    output logic [NCH-1:0][CW-1:0]  cnt,
    output logic [NCH-1:0]          word,
    output logic [NCH-1:0]          bump_src,
    output logic [NCH-1:0][AW-1:0]  src,
    output logic [NCH-1:0][AW-1:0]  dst
);
    typedef struct packed {
        logic [NCH-1:0][CW-1:0] cnt;
        logic [NCH-1:0]         word;
        logic [NCH-1:0]         bump_src;
        logic [NCH-1:0][AW-1:0] src;
        logic [NCH-1:0][AW-1:0] dst;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int c = 0; c < NCH; c++) begin
            if (upd && (upd_ch == CHW'(c))) begin
                if (bank_q.bump_src[c])
                    bank_d.src[c] = bank_q.src[c] + (bank_q.word[c] ? AW'(WSTEP) : AW'(1));
                else
                    bank_d.dst[c] = bank_q.dst[c] + (bank_q.word[c] ? AW'(WSTEP) : AW'(1));
                if (bank_q.cnt[c] != '1)
                    bank_d.cnt[c] = bank_q.cnt[c] - CW'(1);
            end
            if (cfg_we && (cfg_ch == CHW'(c))) begin
                unique case (cfg_sel)
                    SEL_CTRL: begin
                        bank_d.cnt[c]      = cfg_wdata[CW-1:0];
                        bank_d.word[c]     = cfg_wdata[CW];
                        bank_d.bump_src[c] = cfg_wdata[CW+1];
                    end
                    SEL_SRC: bank_d.src[c] = cfg_wdata;
                    SEL_DST: bank_d.dst[c] = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cnt      = bank_q.cnt;
    assign word     = bank_q.word;
    assign bump_src = bank_q.bump_src;
    assign src      = bank_q.src;
    assign dst      = bank_q.dst;
endmodule

// File: rtl/pet_engine.sv
module pet_engine
    import pet_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig_i,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic           mem_word,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic           done_o,
    output logic [CHW-1:0] done_ch,
    output logic [NCH-1:0] irq_o
);
    typedef struct packed {
        pet_state_e     st;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  data;
        logic [NCH-1:0] pend;
        logic           done;
        logic [CHW-1:0] done_ch;
        logic [NCH-1:0] irq;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [NCH-1:0][CW-1:0] cnt;
    logic [NCH-1:0]         word;
    logic [NCH-1:0]         bump_src;
    logic [NCH-1:0][AW-1:0] src;
    logic [NCH-1:0][AW-1:0] dst;
    logic                   pick_any;
    logic [CHW-1:0]         pick_idx;
    logic                   upd;

    pet_pick #(.NCH(NCH)) u_pick (
        .req (eng_q.pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    pet_chan_bank #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .upd       (upd),
        .upd_ch    (eng_q.ch),
        .cnt       (cnt),
        .word      (word),
        .bump_src  (bump_src),
        .src       (src),
        .dst       (dst)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        eng_d.irq  = '0;
        upd        = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (pick_any) begin
                    eng_d.pend[pick_idx] = 1'b0;
                    if (cnt[pick_idx] == '0) begin
                        eng_d.irq[pick_idx] = 1'b1;
                    end else begin
                        eng_d.ch = pick_idx;
                        eng_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    eng_d.data = word[eng_q.ch] ? mem_rdata
                                                : {{(DW-8){1'b0}}, mem_rdata[7:0]};
                    eng_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    upd           = 1'b1;
                    eng_d.done    = 1'b1;
                    eng_d.done_ch = eng_q.ch;
                    eng_d.st      = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
        eng_d.pend = eng_d.pend | trig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign mem_req   = (eng_q.st == ST_READ) || (eng_q.st == ST_WRITE);
    assign mem_we    = (eng_q.st == ST_WRITE);
    assign mem_word  = word[eng_q.ch];
    assign mem_addr  = (eng_q.st == ST_WRITE) ? dst[eng_q.ch] : src[eng_q.ch];
    assign mem_wdata = eng_q.data;
    assign done_o    = eng_q.done;
    assign done_ch   = eng_q.done_ch;
    assign irq_o     = eng_q.irq;
endmodule

// File: rtl/pet_engine_chk.sv
module pet_engine_chk #(
    parameter int NCH = 8,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ack,
    input logic [AW-1:0]  mem_addr,
    input logic           done_o,
    input logic [NCH-1:0] irq_o
);
    // R1: quiet bus while in reset
    always_comb begin
        if (!rst_n) p_reset_quiet_r1: assert (!mem_req);
    end

    // R8: an unanswered request holds address and direction
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: each service opens with a read
    p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !mem_we);

    // R8: completion only after an acknowledged write
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_req && mem_we && mem_ack));

    // R5: at most one interrupt request at a time
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // R5: an interrupt request never coincides with a completed move
    p_irq_not_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> !done_o);
endmodule

bind pet_engine pet_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .done_o   (done_o),
    .irq_o    (irq_o)
);

// File: tb/pet_engine_test.sv
module pet_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trig_i = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        mem_req, mem_we, mem_word;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        done_o;
    logic [2:0]  done_ch;
    logic [7:0]  irq_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int acc_cnt = 0;

    logic [7:0]  mem [0:255];
    logic [15:0] last_ra, last_wa, last_wd;
    logic        last_rw, last_ww;

    pet_engine uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    // memory responder: ack every other cycle while requested
    always @(negedge clk) begin
        if (!rst_n) mem_ack = 1'b0;
        else        mem_ack = mem_req && !mem_ack;
        mem_rdata = {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
    end

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            acc_cnt++;
            if (mem_we) begin
                last_wa = mem_addr; last_ww = mem_word; last_wd = mem_wdata;
                mem[mem_addr[7:0]] = mem_wdata[7:0];
                if (mem_word) mem[mem_addr[7:0] + 8'd1] = mem_wdata[15:8];
            end else begin
                last_ra = mem_addr; last_rw = mem_word;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] ch, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [2:0] ch, input logic [7:0] cnt, input logic w,
                         input logic bs, input logic [7:0] s, input logic [7:0] d);
        cfg(ch, 2'd0, {6'd0, bs, w, cnt});
        cfg(ch, 2'd1, {8'd0, s});
        cfg(ch, 2'd2, {8'd0, d});
    endtask

    task automatic fire(input logic [7:0] m);
        @(negedge clk);
        trig_i = m;
        @(negedge clk);
        trig_i = '0;
    endtask

    // waits for a done or irq pulse; kind 0 none, 1 done, 2 irq
    task automatic wait_evt(output int kind, output logic [2:0] ch, output logic [7:0] irqv);
        kind = 0; ch = '0; irqv = '0;
        for (int i = 0; i < 60; i++) begin
            if (done_o) begin kind = 1; ch = done_ch; break; end
            if (|irq_o) begin kind = 2; irqv = irq_o; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [2:0] ch;
        logic       w;
        logic       bs;
        logic [7:0] s;
        logic [7:0] d;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{3'd0, 1'b0, 1'b0, 8'h10, 8'h80},
        '{3'd3, 1'b1, 1'b1, 8'h20, 8'h90},
        '{3'd7, 1'b1, 1'b0, 8'h30, 8'hA0},
        '{3'd5, 1'b0, 1'b1, 8'h47, 8'hB0}
    };

    initial begin
        int kind;
        logic [2:0] ch;
        logic [7:0] iv;
        int a0;

        for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!mem_req && !done_o && irq_o == 0, "R1 reset outputs", {mem_req, done_o, irq_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !done_o && irq_o == 0, "R1 after reset", {mem_req, done_o, irq_o}, 0);

        // table-driven transfers: R2 R3 R4 R10
        foreach (VEC[k]) begin
            vec_t v = VEC[k];
            int sz = v.w ? 2 : 1;
            setup(v.ch, 8'd5, v.w, v.bs, v.s, v.d);
            fire(8'(1) << v.ch);
            wait_evt(kind, ch, iv);
            check(kind == 1 && ch == v.ch, "R8 done channel", ch, v.ch);
            check(last_ra == {8'd0, v.s} && last_wa == {8'd0, v.d}, "R10 programmed addresses",
                  {last_ra, last_wa}, {8'd0, v.s, 8'd0, v.d});
            if (v.w) begin
                check(last_ww && last_wd == {pat(v.s + 8'd1), pat(v.s)}, "R3 word data",
                      last_wd, {pat(v.s + 8'd1), pat(v.s)});
            end else begin
                check(!last_ww && last_wd == {8'd0, pat(v.s)}, "R2 byte data",
                      last_wd, {8'd0, pat(v.s)});
            end
            fire(8'(1) << v.ch);
            wait_evt(kind, ch, iv);
            if (v.bs)
                check(last_ra == 16'(v.s + sz) && last_wa == {8'd0, v.d}, "R4 source step",
                      {last_ra, last_wa}, {16'(v.s + sz), 8'd0, v.d});
            else
                check(last_ra == {8'd0, v.s} && last_wa == 16'(v.d + sz), "R4 destination step",
                      {last_ra, last_wa}, {8'd0, v.s, 16'(v.d + sz)});
        end

        // R5: counter runs out after two services
        setup(3'd1, 8'd2, 1'b0, 1'b0, 8'h50, 8'hC0);
        fire(8'h02); wait_evt(kind, ch, iv);
        fire(8'h02); wait_evt(kind, ch, iv);
        check(kind == 1 && ch == 3'd1, "R5 second service moves", kind, 1);
        a0 = acc_cnt;
        fire(8'h02); wait_evt(kind, ch, iv);
        check(kind == 2 && iv == 8'h02, "R5 irq on exhausted count", iv, 8'h02);
        check(acc_cnt == a0, "R5 no memory access on irq", acc_cnt - a0, 0);
        fire(8'h02); wait_evt(kind, ch, iv);
        check(kind == 2 && acc_cnt == a0, "R5 count stays zero", kind, 2);

        // R6: continuous channel
        setup(3'd2, 8'hFF, 1'b1, 1'b0, 8'h60, 8'hD0);
        for (int n = 0; n < 4; n++) begin
            fire(8'h04); wait_evt(kind, ch, iv);
            check(kind == 1 && ch == 3'd2, "R6 continuous service", kind, 1);
        end
        check(last_wa == 16'hD6, "R6 fourth write address", last_wa, 16'hD6);

        // R7 R9: simultaneous triggers and retrigger during service
        setup(3'd4, 8'd9, 1'b0, 1'b0, 8'h70, 8'hE0);
        setup(3'd6, 8'd9, 1'b0, 1'b0, 8'h72, 8'hF0);
        fire(8'h50);
        fire(8'h10);
        wait_evt(kind, ch, iv);
        check(kind == 1 && ch == 3'd4, "R7 lowest first", ch, 4);
        wait_evt(kind, ch, iv);
        check(kind == 1 && ch == 3'd4, "R9 retrigger served", ch, 4);
        check(last_wa == 16'hE1, "R9 retrigger address", last_wa, 16'hE1);
        wait_evt(kind, ch, iv);
        check(kind == 1 && ch == 3'd6, "R7 pending later served", ch, 6);

        // R10: write to control word resets the count on a drained channel
        cfg(3'd1, 2'd0, 16'h0001);
        fire(8'h02); wait_evt(kind, ch, iv);
        check(kind == 1 && ch == 3'd1, "R10 reprogrammed count", kind, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule